// File: doc/BRIEF.md
# Multi-Source Interrupt Capture Core

This block collects a wide set of interrupt request lines and turns them into pulses of state on a larger bank of output interrupt lines. For every source it holds a trigger mode (edge or level), a last-seen input level, a pending flag, an in-service flag and a mask bit. Each source also has a vector entry that selects which output line its service events drive.

Service events happen only when something changes: an input toggles, a mask bit flips, or a clear command arrives. An assertion event marks one source as in service and raises its output line. A deassertion event takes one source out of service and lowers its line. Each event acts on the lowest-numbered source that qualifies, and the block handles at most one event per clock. A separate register block supplies the mask, edge-select and vector values and the clear command. That register block reads back the pending, in-service and visible-status vectors. `rst_n` is asynchronous and active low. Its release must already be synchronous to `clk`.

Top module: `irqc_capture_top`

## Requirements
- R1: A source with edge-select 1 sets its pending bit when its input rises from a last-seen level of 0. A falling input updates only the last-seen level, so the pending bit stays set.
- R2: A source with edge-select 0 has a pending bit equal to its input once that input change has been processed.
- R3: On an assertion event, the block takes the lowest-index source among the affected sources that are pending and unmasked. It sets that source's in-service bit and drives `irq_out[vec]` to 1, where `vec` is the source's vector entry. If no source qualifies, nothing changes.
- R4: On a deassertion event, the block takes the lowest-index affected source that is in service. It clears that source's in-service bit and drives its vector's output line to 0.
- R5: A mask write that takes bits from 1 to 0 is an assertion event over those bits. A write that takes bits from 0 to 1 is a deassertion event over those bits. If one write does both, only the assertion event runs.
- R6: A clear command affects only the edge-mode sources named in `clr_bits`. It clears their pending bits and runs a deassertion event over them. It then clears the in-service bits of all of them. Level-mode sources named in the command are left unchanged.
- R7: In a single clock the priority is: clear command first, then mask write, then input changes. An input change that loses this arbitration is processed in a later cycle. When inputs rise and fall in the same cycle, the rising group is handled first and the falling group one cycle later.
- R8: After reset, all mask bits are 1. The pending, in-service, last-level and edge-select bits are 0. Every vector entry is 0 and every output line is 0.
- R9: `status_o` equals `isr_o & ~mask`. `pend_o` and `isr_o` show the pending and in-service bits.
- R10: At most one output line changes per clock, and only through a service event. Writes to the vector table never change an output line.
- R11: A vector write takes effect for events in later cycles. An event in the same cycle as the write still uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt source inputs |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_SRC | New mask value (1 = masked) |
| edge_we | input | 1 | Edge-select write strobe |
| edge_wdata | input | NUM_SRC | New edge-select value (1 = edge mode) |
| vec_we | input | 1 | Vector table write strobe |
| vec_widx | input | IDX_W | Source index of the vector entry to write |
| vec_wdata | input | VEC_W | New vector entry |
| clr_valid | input | 1 | Clear command strobe |
| clr_bits | input | NUM_SRC | Sources named by the clear command |
| irq_out | output | 2**VEC_W | Output interrupt lines |
| pend_o | output | NUM_SRC | Pending bits |
| isr_o | output | NUM_SRC | In-service bits |
| status_o | output | NUM_SRC | In-service bits of unmasked sources |

## Verification
The bench builds the core with eight sources and a 3-bit vector, which gives eight output lines. At that size every one of the 255 non-zero input patterns can be applied as a single rising group and then released. This checks lowest-index selection in both directions against a model kept in the bench. Every vector entry, every single-bit mask transition and every single-bit clear can also be swept across all sources. The small configuration also makes same-cycle collisions cheap to set up: a clear, a mask write and an input change together; rising and falling groups together; and a vector write in the same cycle as an event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_ASSERT   = 2'd1,
    EV_DEASSERT = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/irqc_lowest_pick.sv
module irqc_lowest_pick #(
  parameter int W     = 64,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // scan downward so the lowest set bit is the last one assigned
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_vec_table.sv
module irqc_vec_table #(
  parameter int NUM_SRC = 64,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [VEC_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [VEC_W-1:0] rdata
);
  logic [VEC_W-1:0] tbl_q [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    logic             en;
    logic [VEC_W-1:0] nxt;
    always_comb begin
      en  = we && (widx == IDX_W'(g));
      nxt = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl_q[g] <= '0;
      else if (en) tbl_q[g] <= nxt;
    end
  end

  assign rdata = tbl_q[ridx];
endmodule

// File: rtl/irqc_line_bank.sv
module irqc_line_bank #(
  parameter int VEC_W   = 8,
  parameter int NUM_OUT = 1 << VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               set_val,
  input  logic [VEC_W-1:0]   line,
  output logic [NUM_OUT-1:0] out_q
);
  logic [NUM_OUT-1:0] out_d;

  always_comb begin
    out_d = out_q;
    if (fire) out_d[line] = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (fire) out_q <= out_d;
  end

  assert_one_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_q ^ $past(out_q)) <= 1);
endmodule

// File: rtl/irqc_src_state.sv
module irqc_src_state
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               edge_we,
  input  logic [NUM_SRC-1:0] edge_wdata,
  input  logic               clr_valid,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic               sel_found,
  input  logic [IDX_W-1:0]   sel_idx,
  output ev_kind_t           ev_kind,
  output logic [NUM_SRC-1:0] cand,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] isr_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] edge_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] isr_q, isr_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] edge_q;
  logic [NUM_SRC-1:0] last_q, last_d;
  logic [NUM_SRC-1:0] rise, fall, clr_eff, unmask_set, mask_set;
  logic               state_en;

  always_comb begin
    rise       = src_in & ~last_q;
    fall       = ~src_in & last_q;
    clr_eff    = clr_bits & edge_q;
    unmask_set = mask_q & ~mask_wdata;
    mask_set   = ~mask_q & mask_wdata;
  end

  // event selection and pending / mask / level next state
  always_comb begin
    pend_d  = pend_q;
    mask_d  = mask_q;
    last_d  = last_q;
    ev_kind = EV_NONE;
    cand    = '0;
    if (clr_valid) begin
      pend_d  = pend_q & ~clr_eff;
      ev_kind = EV_DEASSERT;
      cand    = clr_eff & isr_q;
    end else if (mask_we) begin
      mask_d = mask_wdata;
      if (|unmask_set) begin
        ev_kind = EV_ASSERT;
        cand    = unmask_set & pend_q & ~mask_wdata;
      end else if (|mask_set) begin
        ev_kind = EV_DEASSERT;
        cand    = mask_set & isr_q;
      end
    end else if (|rise) begin
      last_d  = last_q | rise;
      pend_d  = pend_q | rise;
      ev_kind = EV_ASSERT;
      cand    = rise & ~mask_q;
    end else if (|fall) begin
      last_d  = last_q & ~fall;
      pend_d  = pend_q & ~(fall & ~edge_q);
      ev_kind = EV_DEASSERT;
      cand    = fall & isr_q;
    end
  end

  // in-service next state from the chosen source
  always_comb begin
    isr_d = isr_q;
    if (sel_found) begin
      if (ev_kind == EV_ASSERT)   isr_d[sel_idx] = 1'b1;
      if (ev_kind == EV_DEASSERT) isr_d[sel_idx] = 1'b0;
    end
    if (clr_valid) isr_d = isr_d & ~clr_eff;
  end

  assign state_en = clr_valid | mask_we | (|rise) | (|fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      last_q <= '0;
    end else if (state_en) begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
      mask_q <= mask_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       edge_q <= '0;
    else if (edge_we) edge_q <= edge_wdata;
  end

  assign pend_o = pend_q;
  assign isr_o  = isr_q;
  assign mask_o = mask_q;
  assign edge_o = edge_q;

  // a newly in-service source must be pending and unmasked
  assert_isr_gain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q)) & (~pend_q | mask_q)) == '0);

  // no more than one source enters service per clock
  assert_isr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  // edge-mode pending bits drop only under a clear command
  assert_edge_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) & ~pend_q & $past(edge_q)
     & ~($past(clr_bits) & {NUM_SRC{$past(clr_valid)}})) == '0);
endmodule

// File: rtl/irqc_capture_top.sv
module irqc_capture_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = $clog2(NUM_SRC),
  parameter int NUM_OUT = 1 << VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               edge_we,
  input  logic [NUM_SRC-1:0] edge_wdata,
  input  logic               vec_we,
  input  logic [IDX_W-1:0]   vec_widx,
  input  logic [VEC_W-1:0]   vec_wdata,
  input  logic               clr_valid,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_OUT-1:0] irq_out,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] isr_o,
  output logic [NUM_SRC-1:0] status_o
);
  ev_kind_t           ev_kind;
  logic [NUM_SRC-1:0] cand, mask_w, edge_w;
  logic               sel_found;
  logic [IDX_W-1:0]   sel_idx;
  logic [VEC_W-1:0]   sel_line;
  logic               fire, set_val;

  irqc_src_state #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .edge_we(edge_we), .edge_wdata(edge_wdata),
    .clr_valid(clr_valid), .clr_bits(clr_bits),
    .sel_found(sel_found), .sel_idx(sel_idx),
    .ev_kind(ev_kind), .cand(cand),
    .pend_o(pend_o), .isr_o(isr_o), .mask_o(mask_w), .edge_o(edge_w)
  );

  irqc_lowest_pick #(.W(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .found(sel_found), .idx(sel_idx)
  );

  irqc_vec_table #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .we(vec_we), .widx(vec_widx),
    .wdata(vec_wdata), .ridx(sel_idx), .rdata(sel_line)
  );

  assign fire    = sel_found && (ev_kind != EV_NONE);
  assign set_val = (ev_kind == EV_ASSERT);

  irqc_line_bank #(.VEC_W(VEC_W), .NUM_OUT(NUM_OUT)) u_lines (
    .clk(clk), .rst_n(rst_n), .fire(fire), .set_val(set_val),
    .line(sel_line), .out_q(irq_out)
  );

  assign status_o = isr_o & ~mask_w;

  // a clear naming no edge-mode source leaves pending bits alone
  assert_clear_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && ((clr_bits & edge_w) == '0)) |=> $stable(pend_o));
endmodule

// File: tb/sim_irqc_capture_top.sv
module sim_irqc_capture_top;
  localparam int S = 8;
  localparam int V = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [S-1:0] src_in, mask_wdata, edge_wdata, clr_bits;
  logic mask_we, edge_we, vec_we, clr_valid;
  logic [2:0] vec_widx;
  logic [V-1:0] vec_wdata;
  logic [7:0] irq_out, pend_o, isr_o, status_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_pend, m_isr, m_mask, m_edge, m_last, m_out;
  logic [2:0] m_vec [S];

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqc_capture_top #(.NUM_SRC(S), .VEC_W(V)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .edge_we(edge_we), .edge_wdata(edge_wdata),
    .vec_we(vec_we), .vec_widx(vec_widx), .vec_wdata(vec_wdata),
    .clr_valid(clr_valid), .clr_bits(clr_bits),
    .irq_out(irq_out), .pend_o(pend_o), .isr_o(isr_o), .status_o(status_o)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    logic [7:0] c, up, dn, rise, fall;
    int k;
    if (clr_valid) begin
      c = clr_bits & m_edge;
      m_pend &= ~c;
      k = lowest(c & m_isr);
      if (k >= 0) m_out[m_vec[k]] = 1'b0;
      m_isr &= ~c;
    end else if (mask_we) begin
      up = m_mask & ~mask_wdata;
      dn = ~m_mask & mask_wdata;
      m_mask = mask_wdata;
      if (up != 0) begin
        k = lowest(up & m_pend & ~m_mask);
        if (k >= 0) begin m_isr[k] = 1'b1; m_out[m_vec[k]] = 1'b1; end
      end else if (dn != 0) begin
        k = lowest(dn & m_isr);
        if (k >= 0) begin m_isr[k] = 1'b0; m_out[m_vec[k]] = 1'b0; end
      end
    end else begin
      rise = src_in & ~m_last;
      fall = ~src_in & m_last;
      if (rise != 0) begin
        m_last |= rise;
        m_pend |= rise;
        k = lowest(rise & ~m_mask);
        if (k >= 0) begin m_isr[k] = 1'b1; m_out[m_vec[k]] = 1'b1; end
      end else if (fall != 0) begin
        m_last &= ~fall;
        m_pend &= ~(fall & ~m_edge);
        k = lowest(fall & m_isr);
        if (k >= 0) begin m_isr[k] = 1'b0; m_out[m_vec[k]] = 1'b0; end
      end
    end
    if (edge_we) m_edge = edge_wdata;
    if (vec_we) m_vec[vec_widx] = vec_wdata;
  endtask

  task automatic step(input string tag);
    model_update();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "pend", pend_o, m_pend);
    chk(tag, "isr", isr_o, m_isr);
    chk(tag, "irq_out", irq_out, m_out);
    chk(tag, "status", status_o, m_isr & ~m_mask);
    mask_we = 1'b0; edge_we = 1'b0; vec_we = 1'b0; clr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_in = '0; mask_wdata = '0; edge_wdata = '0; clr_bits = '0;
    mask_we = 1'b0; edge_we = 1'b0; vec_we = 1'b0; clr_valid = 1'b0;
    vec_widx = '0; vec_wdata = '0;
    m_pend = '0; m_isr = '0; m_mask = '1; m_edge = '0; m_last = '0; m_out = '0;
    for (int i = 0; i < S; i++) m_vec[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state, then a rising input stays hidden by the reset mask
    chk("R8", "pend", pend_o, 8'h00);
    chk("R8", "isr", isr_o, 8'h00);
    chk("R8", "irq_out", irq_out, 8'h00);
    chk("R8", "status", status_o, 8'h00);
    src_in = 8'h01; step("R8");
    src_in = 8'h00; step("R2");

    // R11: program a one-to-one vector map
    for (int i = 0; i < S; i++) begin
      vec_we = 1'b1; vec_widx = 3'(i); vec_wdata = 3'((i * 3 + 1) & 7);
      step("R11");
    end
    mask_we = 1'b1; mask_wdata = 8'h00; step("R5");

    // R3 / R4 / R2: every non-zero pattern as one level-mode group
    for (int p = 1; p < 256; p++) begin
      src_in = 8'(p); step("R3");
      src_in = 8'h00; step("R4");
    end

    // R1 / R6: edge mode per source
    edge_we = 1'b1; edge_wdata = 8'hFF; step("R1");
    for (int i = 0; i < S; i++) begin
      src_in = 8'(1 << i); step("R1");
      src_in = 8'h00; step("R1");
      clr_valid = 1'b1; clr_bits = 8'(1 << i); step("R6");
    end
    // edge pending held and in service, then cleared as a group
    src_in = 8'h06; step("R1");
    clr_valid = 1'b1; clr_bits = 8'h0F; step("R6");
    src_in = 8'h00; step("R1");

    // R6: clear on level-mode sources has no effect
    edge_we = 1'b1; edge_wdata = 8'h00; step("R6");
    src_in = 8'h30; step("R2");
    clr_valid = 1'b1; clr_bits = 8'hFF; step("R6");
    src_in = 8'h00; step("R2");

    // R5: mask transitions per source with all inputs high
    src_in = 8'hFF; step("R2");
    mask_we = 1'b1; mask_wdata = 8'hFF; step("R5");
    for (int i = 0; i < S; i++) begin
      mask_we = 1'b1; mask_wdata = ~8'(1 << i); step("R5");
      mask_we = 1'b1; mask_wdata = 8'hFF; step("R5");
    end
    mask_we = 1'b1; mask_wdata = 8'h0F; step("R5");
    mask_we = 1'b1; mask_wdata = 8'hF0; step("R5");
    mask_we = 1'b1; mask_wdata = 8'h00; step("R9");
    src_in = 8'h00; step("R2");
    step("R4");

    // R7: clear, mask write and input change in one cycle
    edge_we = 1'b1; edge_wdata = 8'h55; step("R7");
    src_in = 8'h01; step("R7");
    clr_valid = 1'b1; clr_bits = 8'h01;
    mask_we = 1'b1; mask_wdata = 8'h80; src_in = 8'h03; step("R7");
    step("R7");
    step("R7");
    // rising and falling groups in one cycle
    src_in = 8'h0F; step("R7");
    src_in = 8'hF0; step("R7");
    step("R7");

    // R11 / R10: vector write in the same cycle as an event
    src_in = 8'h00; step("R10");
    step("R10");
    edge_we = 1'b1; edge_wdata = 8'h00; step("R10");
    vec_we = 1'b1; vec_widx = 3'd2; vec_wdata = 3'd0; src_in = 8'h04; step("R11");
    vec_we = 1'b1; vec_widx = 3'd2; vec_wdata = 3'd5; step("R10");
    src_in = 8'h00; step("R11");
    src_in = 8'h04; step("R11");
    src_in = 8'h00; step("R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule